// File: doc/BRIEF.md
# Hash Unit Register and Error-Interrupt Front End

This block sits in front of the hashing engine of a security accelerator. It decodes register reads and writes from the bus, holds the interrupt mask and the interrupt status, and drives one error interrupt line toward the accelerator's controller. Writing a legal byte count to the size register starts processing on its own. Firmware must therefore load any hashing context before it writes the size. The hash datapath is represented by a single consume strobe. Each pulse uses up one chunk of four bytes while `go_o` is high.

Any pending unmasked error halts the engine. The remaining byte count is kept so that software can inspect it. The error line follows the status register one cycle late. Processing does not restart by itself when the errors are cleared: it needs a fresh size write. A three-bit reset control register clears the state at three levels: all state, engine state without the mask, or the error status only. Its bits read back as zero.

Bus writes take effect at the clock edge where `wr_en` is high. Read data appears on `rdata` one cycle after `rd_en`. The register offsets are word indices: 0 size, 1 reset control, 2 status, 3 mask, 4 interrupt status. Offsets 5 to 7 are unmapped.

Top module: `hash_eu_regs`

## Requirements
- R1: After synchronous reset the size, mask and interrupt status are zero, `irq_o` and `go_o` are low, and a status read returns 0x00000008.
- R2: Writing a legal size (nonzero, low two bits zero, no bits set above bit 15) to offset 0 loads it and raises `go_o` from the next cycle.
- R3: Each `consume_i` pulse while `go_o` is high lowers the size by 4. When the size reaches zero, `go_o` drops and the done flag is set.
- R4: Writing an illegal size sets interrupt status bit 0 (size error), leaves the size unchanged and does not start processing.
- R5: A write to offset 2 or to offsets 5 to 7 sets interrupt status bit 1 (address error). Reads of offsets 5 to 7 return zero.
- R6: A `consume_i` pulse while not running and with no error pending sets interrupt status bit 2 (overrun).
- R7: Interrupt status bit i can become set only while mask bit i (offset 3) is zero.
- R8: While the interrupt status is nonzero, `go_o` is low and the size keeps its value. After the errors are cleared, processing stays stopped until the next size write.
- R9: `irq_o` equals the OR of the interrupt status bits delayed by one cycle, on both rising and falling transitions.
- R10: A write to offset 4 stores each written 1 whose mask bit is zero and clears all other status bits.
- R11: Writing offset 1 acts as follows. Bit 2 clears the interrupt status only. Bit 1 clears the size, done flag and interrupt status and stops the engine, but keeps the mask. Bit 0 clears all of these and the mask as well. Offset 1 reads as zero.
- R12: A status read returns busy at bit 0, done at bit 1, error pending at bit 2, idle (not running and no error) at bit 3, and the remaining size in bits 31:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register word offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| consume_i | input | 1 | Datapath used one 4-byte chunk |
| go_o | output | 1 | Engine may process data |
| irq_o | output | 1 | Error interrupt to the controller |

## Verification
The countdown is driven with a multi-chunk size taken to completion, and with a size that is interrupted mid-way by an address error. These two cases separate normal completion, where the count reaches zero and the done flag is set, from a halt, where the count is frozen and no restart occurs after the errors are cleared. Illegal sizes, writes to the read-only status register and to unmapped offsets, and consume strobes with nothing loaded each produce a different status bit. These sources are replayed with the mask fully set, to show that a masked source leaves no trace. Status writes with and without mask bits set separate the keep-unmasked-ones rule from a plain register store. The three reset control bits are applied one at a time, so their reach over size, status and mask can be told apart.

// File: rtl/hash_eu_pkg.sv
package hash_eu_pkg;
  localparam int IRQ_W = 3;
  localparam int IRQ_DSE = 0;
  localparam int IRQ_AE  = 1;
  localparam int IRQ_ORE = 2;

  localparam logic [2:0] OFS_SIZE = 3'd0;
  localparam logic [2:0] OFS_RST  = 3'd1;
  localparam logic [2:0] OFS_STAT = 3'd2;
  localparam logic [2:0] OFS_IMR  = 3'd3;
  localparam logic [2:0] OFS_ISR  = 3'd4;

  localparam int RST_ALL  = 0;
  localparam int RST_INIT = 1;
  localparam int RST_IRQ  = 2;
endpackage

// File: rtl/hash_eu_size.sv
module hash_eu_size #(
  parameter int SIZE_W     = 16,
  parameter int CHUNK_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              load,
  input  logic [SIZE_W-1:0] load_val,
  input  logic              consume,
  input  logic              halt,
  output logic [SIZE_W-1:0] size_q,
  output logic              run_q,
  output logic              done_q,
  output logic              ore_evt
);
  localparam logic [SIZE_W-1:0] STEP = SIZE_W'(1 << CHUNK_LOG2);

  // overrun: data arrives with nothing loaded and no error pending
  assign ore_evt = consume && !run_q && !halt && !clr;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      size_q <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (load) begin
      size_q <= load_val;
      run_q  <= 1'b1;
      done_q <= 1'b0;
    end else if (halt) begin
      run_q  <= 1'b0;
    end else if (consume && run_q) begin
      size_q <= size_q - STEP;
      if (size_q == STEP) begin
        run_q  <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  // R8: count frozen while an error is pending
  p_size_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (halt && !clr && !load) |=> $stable(size_q));

  // R3: completion leaves the count at zero
  p_done_zero_r3: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (size_q == '0));
endmodule

// File: rtl/hash_eu_isr.sv
module hash_eu_isr
  import hash_eu_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_isr,
  input  logic             clr_imr,
  input  logic             isr_wr,
  input  logic             imr_wr,
  input  logic [IRQ_W-1:0] wval,
  input  logic [IRQ_W-1:0] evt,
  output logic [IRQ_W-1:0] isr_q,
  output logic [IRQ_W-1:0] imr_q,
  output logic             irq_o
);
  always_ff @(posedge clk) begin
    if (rst || clr_imr) imr_q <= '0;
    else if (imr_wr)    imr_q <= wval;
  end

  for (genvar i = 0; i < IRQ_W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || clr_isr)              isr_q[i] <= 1'b0;
      else if (isr_wr)                 isr_q[i] <= (wval[i] | evt[i]) & ~imr_q[i];
      else if (evt[i] && !imr_q[i])    isr_q[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |isr_q;
  end

  // R7: a masked bit never rises
  p_mask_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((isr_q & ~$past(isr_q) & $past(imr_q)) == '0));

  // R9: interrupt line trails the status by one cycle
  p_irq_rise_r9: assert property (@(posedge clk) disable iff (rst)
    (|isr_q) |=> irq_o);
  p_irq_fall_r9: assert property (@(posedge clk) disable iff (rst)
    (isr_q == '0) |=> !irq_o);
endmodule

// File: rtl/hash_eu_regs.sv
module hash_eu_regs
  import hash_eu_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 3,
  parameter int SIZE_W     = 16,
  parameter int CHUNK_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              consume_i,
  output logic              go_o,
  output logic              irq_o
);
  localparam int STAT_SIZE_LSB = 16;

  logic [ADDR_W-1:0] ofs_size, ofs_rst, ofs_stat, ofs_imr, ofs_isr;
  assign ofs_size = ADDR_W'(OFS_SIZE);
  assign ofs_rst  = ADDR_W'(OFS_RST);
  assign ofs_stat = ADDR_W'(OFS_STAT);
  assign ofs_imr  = ADDR_W'(OFS_IMR);
  assign ofs_isr  = ADDR_W'(OFS_ISR);

  logic wr_size, size_ok, load, dse, wr_rst, rst_all, rst_init, rst_irq, ae;
  logic [SIZE_W-1:0] size_q;
  logic run_q, done_q, ore;
  logic [IRQ_W-1:0] isr_q, imr_q, evt;
  logic halt;

  assign wr_size  = wr_en && (addr == ofs_size);
  assign size_ok  = (wdata != '0) && (wdata[CHUNK_LOG2-1:0] == '0) &&
                    ((wdata >> SIZE_W) == '0);
  assign load     = wr_size && size_ok;
  assign dse      = wr_size && !size_ok;
  assign wr_rst   = wr_en && (addr == ofs_rst);
  assign rst_all  = wr_rst && wdata[RST_ALL];
  assign rst_init = wr_rst && wdata[RST_INIT];
  assign rst_irq  = wr_rst && wdata[RST_IRQ];
  assign ae       = wr_en && ((addr == ofs_stat) || (addr > ofs_isr));
  assign halt     = |isr_q;

  always_comb begin
    evt = '0;
    evt[IRQ_DSE] = dse;
    evt[IRQ_AE]  = ae;
    evt[IRQ_ORE] = ore;
  end

  hash_eu_size #(.SIZE_W(SIZE_W), .CHUNK_LOG2(CHUNK_LOG2)) u_size (
    .clk(clk), .rst(rst), .clr(rst_all || rst_init), .load(load),
    .load_val(wdata[SIZE_W-1:0]), .consume(consume_i), .halt(halt),
    .size_q(size_q), .run_q(run_q), .done_q(done_q), .ore_evt(ore)
  );

  hash_eu_isr u_isr (
    .clk(clk), .rst(rst), .clr_isr(rst_all || rst_init || rst_irq),
    .clr_imr(rst_all), .isr_wr(wr_en && (addr == ofs_isr)),
    .imr_wr(wr_en && (addr == ofs_imr)), .wval(wdata[IRQ_W-1:0]),
    .evt(evt), .isr_q(isr_q), .imr_q(imr_q), .irq_o(irq_o)
  );

  assign go_o = run_q && !halt;

  logic [DATA_W-1:0] stat, rd_mux;
  always_comb begin
    stat = '0;
    stat[0] = run_q;
    stat[1] = done_q;
    stat[2] = halt;
    stat[3] = !run_q && !halt;
    stat[STAT_SIZE_LSB +: SIZE_W] = size_q;
  end

  always_comb begin
    rd_mux = '0;
    if (addr == ofs_size)     rd_mux = DATA_W'(size_q);
    else if (addr == ofs_stat) rd_mux = stat;
    else if (addr == ofs_imr)  rd_mux = DATA_W'(imr_q);
    else if (addr == ofs_isr)  rd_mux = DATA_W'(isr_q);
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R5: status register is read-only
  p_ro_status_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ofs_stat && !imr_q[IRQ_AE]) |=> isr_q[IRQ_AE]);

  // R8: no processing while an error is pending
  p_halt_stops_r8: assert property (@(posedge clk) disable iff (rst)
    $past(halt) && !$past(load) |-> !run_q);

  // R2: legal size write starts the engine
  p_load_starts_r2: assert property (@(posedge clk) disable iff (rst)
    (load && !wr_rst) |=> run_q);
endmodule

// File: tb/hash_eu_regs_tb.sv
module hash_eu_regs_tb;
  logic clk = 0;
  logic rst = 1;
  logic wr_en = 0, rd_en = 0, consume_i = 0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic go_o, irq_o;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  hash_eu_regs u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .consume_i(consume_i), .go_o(go_o),
    .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0;
    d = rdata;
  endtask

  task automatic pulse();
    @(negedge clk);
    consume_i = 1;
    @(negedge clk);
    consume_i = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd2, v); check("R1 status", v, 32'h8);
    rd(3'd0, v); check("R1 size", v, 0);
    rd(3'd4, v); check("R1 isr", v, 0);
    rd(3'd3, v); check("R1 imr", v, 0);
    check("R1 irq", irq_o, 0);
    check("R1 go", go_o, 0);
    rd(3'd1, v); check("R11 rst reg reads 0", v, 0);
  endtask

  task automatic t_run();
    logic [31:0] v;
    wr(3'd0, 32'd12);
    check("R2 go after size", go_o, 1);
    rd(3'd2, v); check("R12 busy status", v, 32'h000C_0001);
    pulse(); pulse();
    rd(3'd0, v); check("R3 size after 2", v, 32'd4);
    check("R3 still go", go_o, 1);
    pulse();
    check("R3 go drops", go_o, 0);
    rd(3'd2, v); check("R12 done status", v, 32'h0000_000A);
  endtask

  task automatic t_illegal();
    logic [31:0] v;
    wr(3'd0, 32'd6);
    rd(3'd4, v); check("R4 dse bit", v, 32'h1);
    check("R9 irq rises", irq_o, 1);
    check("R4 no start", go_o, 0);
    rd(3'd0, v); check("R4 size kept", v, 0);
    wr(3'd0, 32'h0001_0000);
    rd(3'd0, v); check("R4 too big ignored", v, 0);
    wr(3'd4, 32'h0);
    rd(3'd4, v); check("R10 isr cleared", v, 0);
    check("R9 irq falls", irq_o, 0);
  endtask

  task automatic t_addr();
    logic [31:0] v;
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd4, v); check("R5 ro status write", v, 32'h2);
    wr(3'd4, 0);
    wr(3'd6, 32'h5);
    rd(3'd4, v); check("R5 unmapped write", v, 32'h2);
    rd(3'd6, v); check("R5 unmapped read", v, 0);
    wr(3'd4, 32'h5);
    rd(3'd4, v); check("R10 ones recorded", v, 32'h5);
    wr(3'd3, 32'h4);
    wr(3'd4, 32'h7);
    rd(3'd4, v); check("R10 masked dropped", v, 32'h3);
    wr(3'd4, 0);
    wr(3'd3, 0);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(3'd3, 32'h7);
    wr(3'd2, 32'h1);
    wr(3'd0, 32'd3);
    pulse();
    rd(3'd4, v); check("R7 masked sources", v, 0);
    check("R7 irq low", irq_o, 0);
    wr(3'd3, 0);
  endtask

  task automatic t_ore();
    logic [31:0] v;
    pulse();
    rd(3'd4, v); check("R6 overrun", v, 32'h4);
    wr(3'd1, 32'h4);
    rd(3'd4, v); check("R11 irq clear", v, 0);
  endtask

  task automatic t_halt();
    logic [31:0] v;
    wr(3'd0, 32'd16);
    pulse();
    wr(3'd7, 0);
    check("R8 go low on error", go_o, 0);
    pulse(); pulse();
    rd(3'd0, v); check("R8 size frozen", v, 32'd12);
    rd(3'd4, v); check("R8 no overrun while halted", v, 32'h2);
    wr(3'd4, 0);
    check("R8 stays stopped", go_o, 0);
    rd(3'd0, v); check("R8 size kept after clear", v, 32'd12);
    wr(3'd0, 32'd8);
    check("R8 restart by size", go_o, 1);
  endtask

  task automatic t_reinit();
    logic [31:0] v;
    wr(3'd3, 32'h2);
    wr(3'd1, 32'h2);
    check("R11 init stops", go_o, 0);
    rd(3'd0, v); check("R11 init clears size", v, 0);
    rd(3'd3, v); check("R11 init keeps mask", v, 32'h2);
    wr(3'd1, 32'h1);
    rd(3'd3, v); check("R11 full clears mask", v, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_run();
    t_illegal();
    t_addr();
    t_mask();
    t_ore();
    t_halt();
    t_reinit();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule